// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer for a large chip. Software reaches it through a simple word-wide register port. The timer itself advances on a slow timebase, nominally 32 kHz. The block receives that timebase as a one-cycle tick enable, `tmr_tick`, in the bus clock domain.

Every register that software writes is posted. The write lands in a shadow word and raises a pending flag in the status register. The write takes effect in the timer logic at the next tick, and only then does the flag clear. Software polls these flags before issuing a dependent write.

The counter counts upward from a programmable load value. An optional power-of-two prescaler slows it down. The counter runs only after a two-word key sequence, and a different two-word key sequence stops it. Software services the watchdog by writing a trigger value that differs from the last one, which reloads the counter. If the counter wraps past all-ones while running, the block pulses a reset request and starts again from the load value.

Register byte offsets: revision 0x00, control 0x04, counter (read-only) 0x08, load 0x0C, trigger 0x10, key 0x14, status 0x18. The key register reads as zero, and unmapped offsets read as zero.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset the timer is stopped and the following read as zero: control, load, counter, trigger and status. `rst_req` is low.
- R2: A write to control, load, trigger or key sets its status pending bit (bit 0, 2, 3 or 4 respectively). The readable value is unchanged until the next `tmr_tick`. On that tick the value takes effect and the bit clears.
- R3: If a write to a register coincides with a tick that applies an earlier pending write to the same register, the earlier value takes effect and the bit stays set. The newer value takes effect on the following tick.
- R4: The key word 0x0000BBBB followed by 0x00004444 starts the timer.
- R5: The key word 0x0000AAAA followed by 0x00005555 stops the timer.
- R6: Any word other than the expected second key after a first key returns the sequence checker to idle, and the run state is unchanged.
- R7: An applied trigger value that differs from the previous one loads the counter with the load register, taking priority over counting.
- R8: An applied trigger value equal to the previous one does not reload the counter.
- R9: With the prescaler off, a running counter advances by one per tick. A stopped counter holds its value.
- R10: Control bit 5 enables the prescaler and bits 4:2 hold a ratio value N. When enabled, the counter advances once every 2^N ticks, with the divider restarted when control is applied. When disabled, every tick counts.
- R11: When a running counter steps past all-ones, `rst_req` is high for exactly one clock cycle and the counter reloads from the load register.
- R12: The revision register returns the 8-bit parameter `REV_ID` in bits 7:0 and zero above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_tick | input | 1 | One-cycle enable marking each slow timebase period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on watchdog expiry |

## Verification
A bus write and the tick that applies an earlier posted write to the same register can fall in the same clock cycle. The bench provokes this by writing the load register and then issuing a second load write with `tmr_tick` asserted in the same cycle. It judges the result by reading the load register and the status bit after that edge, and again after one more tick: the first value must be visible with the flag still set, then the second value with the flag clear. A trigger reload that lands on the tick where the counter would step is judged by reading the counter, which must show the load value and not load plus one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int ADDR_W = 5;
  localparam int NSLOT  = 4;

  localparam logic [ADDR_W-1:0] A_REV  = 5'h00;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'h04;
  localparam logic [ADDR_W-1:0] A_CNT  = 5'h08;
  localparam logic [ADDR_W-1:0] A_LOAD = 5'h0C;
  localparam logic [ADDR_W-1:0] A_TRIG = 5'h10;
  localparam logic [ADDR_W-1:0] A_KEY  = 5'h14;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h18;

  // posted slot indices
  localparam int S_CTRL = 0;
  localparam int S_LOAD = 1;
  localparam int S_TRIG = 2;
  localparam int S_KEY  = 3;

  // control field positions (software depends on them)
  localparam int CB_PEN  = 5;
  localparam int PTV_LSB = 2;
  localparam int PTV_W   = 3;

  localparam logic [15:0] KEY_ON1  = 16'hBBBB;
  localparam logic [15:0] KEY_ON2  = 16'h4444;
  localparam logic [15:0] KEY_OFF1 = 16'hAAAA;
  localparam logic [15:0] KEY_OFF2 = 16'h5555;

  typedef enum logic [1:0] {
    KS_IDLE    = 2'd0,
    KS_ARM_ON  = 2'd1,
    KS_ARM_OFF = 2'd2
  } key_st_e;

  function automatic logic [ADDR_W-1:0] slot_addr(input int i);
    case (i)
      S_CTRL:  slot_addr = A_CTRL;
      S_LOAD:  slot_addr = A_LOAD;
      S_TRIG:  slot_addr = A_TRIG;
      default: slot_addr = A_KEY;
    endcase
  endfunction

  function automatic int slot_pbit(input int i);
    case (i)
      S_CTRL:  slot_pbit = 0;
      S_LOAD:  slot_pbit = 2;
      S_TRIG:  slot_pbit = 3;
      default: slot_pbit = 4;
    endcase
  endfunction

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         tick_i,
  output logic         pend_o,
  output logic         apply_o,
  output logic [W-1:0] data_o
);
  logic         pend_q, pend_d;
  logic [W-1:0] shad_q, shad_d;

  assign apply_o = tick_i & pend_q;

  always_comb begin
    shad_d = shad_q;
    pend_d = pend_q;
    if (apply_o) pend_d = 1'b0;
    if (wr_i) begin
      shad_d = wdata_i;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      shad_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_i) shad_q <= shad_d;
    end
  end

  assign pend_o = pend_q;
  assign data_o = shad_q;

  a_r2_pend_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> pend_o);
  a_r2_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_o && !wr_i) |=> !pend_o);
  a_r3_collide_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && apply_o) |=> (pend_o && data_o == $past(wdata_i)));
endmodule

// File: rtl/wdt_regbank.sv
module wdt_regbank
  import wdt_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [7:0]  REV_ID = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pen_o,
  output logic [PTV_W-1:0]  ptv_o,
  output logic              ctrl_apply_o,
  output logic [DATA_W-1:0] load_o,
  output logic              reload_o,
  output logic              key_apply_o,
  output logic [DATA_W-1:0] key_word_o
);
  logic [NSLOT-1:0]  wr_slot, pend, apply;
  logic [DATA_W-1:0] shad [NSLOT];

  logic [DATA_W-1:0] ctrl_q, load_q, trig_q;
  logic [DATA_W-1:0] stat;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign wr_slot[i] = wr_i & (addr_i == slot_addr(i));
    wdt_post_slot #(.W(DATA_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_slot[i]),
      .wdata_i (wdata_i),
      .tick_i  (tick_i),
      .pend_o  (pend[i]),
      .apply_o (apply[i]),
      .data_o  (shad[i])
    );
  end

  // active copies in the timer view, updated only by an applying tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      trig_q <= '0;
    end else begin
      if (apply[S_CTRL]) ctrl_q <= shad[S_CTRL];
      if (apply[S_LOAD]) load_q <= shad[S_LOAD];
      if (apply[S_TRIG]) trig_q <= shad[S_TRIG];
    end
  end

  assign pen_o        = ctrl_q[CB_PEN];
  assign ptv_o        = ctrl_q[PTV_LSB +: PTV_W];
  assign ctrl_apply_o = apply[S_CTRL];
  assign load_o       = load_q;
  assign reload_o     = apply[S_TRIG] & (shad[S_TRIG] != trig_q);
  assign key_apply_o  = apply[S_KEY];
  assign key_word_o   = shad[S_KEY];

  always_comb begin
    stat = '0;
    for (int i = 0; i < NSLOT; i++) stat[slot_pbit(i)] = pend[i];
  end

  always_comb begin
    case (addr_i)
      A_REV:   rdata_o = DATA_W'(REV_ID);
      A_CTRL:  rdata_o = ctrl_q;
      A_CNT:   rdata_o = cnt_i;
      A_LOAD:  rdata_o = load_q;
      A_TRIG:  rdata_o = trig_q;
      A_STAT:  rdata_o = stat;
      default: rdata_o = '0;
    endcase
  end

  a_r8_same_trig_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (apply[S_TRIG] && shad[S_TRIG] == trig_q) |-> !reload_o);
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              run_o
);
  key_st_e st_q, st_d;
  logic    run_q, run_d;

  logic is_on1, is_on2, is_off1, is_off2;
  assign is_on1  = (word_i == DATA_W'(KEY_ON1));
  assign is_on2  = (word_i == DATA_W'(KEY_ON2));
  assign is_off1 = (word_i == DATA_W'(KEY_OFF1));
  assign is_off2 = (word_i == DATA_W'(KEY_OFF2));

  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    if (apply_i) begin
      st_d = KS_IDLE;
      case (st_q)
        KS_IDLE: begin
          if (is_on1)       st_d = KS_ARM_ON;
          else if (is_off1) st_d = KS_ARM_OFF;
        end
        KS_ARM_ON:  if (is_on2)  run_d = 1'b1;
        KS_ARM_OFF: if (is_off2) run_d = 1'b0;
        default:    st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= KS_IDLE;
      run_q <= 1'b0;
    end else if (apply_i) begin
      st_q  <= st_d;
      run_q <= run_d;
    end
  end

  assign run_o = run_q;

  a_r6_run_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_i |=> $stable(run_q));
  a_r4_start_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(st_q == KS_ARM_ON && is_on2));
  a_r5_stop_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(st_q == KS_ARM_OFF && is_off2));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             pen_i,
  input  logic [PTV_W-1:0] ptv_i,
  output logic             step_o
);
  localparam int DIV_W = (1 << PTV_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, mask;
  logic             hit;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (32'(i) < 32'(ptv_i));
  end

  assign hit    = pen_i ? ((div_q & mask) == mask) : 1'b1;
  assign step_o = tick_i & run_i & hit;

  always_comb begin
    div_d = div_q;
    if (clr_i)                div_d = '0;
    else if (tick_i && run_i) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  a_r10_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (tick_i && run_i));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         reload_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = 1'b0;
    if (reload_i) begin
      cnt_d = load_i;
    end else if (step_i) begin
      if (&cnt_q) begin
        cnt_d = load_i;
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (reload_i || step_i) cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  a_r7_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> cnt_q == $past(load_i));
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !reload_i) |=> $stable(cnt_q));
  a_r11_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(step_i && !reload_i && (&cnt_q)));
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int         DATA_W = 32,
  parameter logic [7:0] REV_ID = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  logic              srst_n;
  logic              pen, ctrl_apply, reload, key_apply, run, step;
  logic [PTV_W-1:0]  ptv;
  logic [DATA_W-1:0] load, key_word, cnt;

  wdt_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (srst_n)
  );

  wdt_regbank #(.DATA_W(DATA_W), .REV_ID(REV_ID)) u_regs (
    .clk          (clk),
    .rst_n        (srst_n),
    .tick_i       (tmr_tick),
    .wr_i         (bus_wr),
    .addr_i       (bus_addr),
    .wdata_i      (bus_wdata),
    .cnt_i        (cnt),
    .rdata_o      (bus_rdata),
    .pen_o        (pen),
    .ptv_o        (ptv),
    .ctrl_apply_o (ctrl_apply),
    .load_o       (load),
    .reload_o     (reload),
    .key_apply_o  (key_apply),
    .key_word_o   (key_word)
  );

  wdt_key_seq #(.DATA_W(DATA_W)) u_key (
    .clk     (clk),
    .rst_n   (srst_n),
    .apply_i (key_apply),
    .word_i  (key_word),
    .run_o   (run)
  );

  wdt_prescale u_pre (
    .clk    (clk),
    .rst_n  (srst_n),
    .tick_i (tmr_tick),
    .run_i  (run),
    .clr_i  (reload | ctrl_apply),
    .pen_i  (pen),
    .ptv_i  (ptv),
    .step_o (step)
  );

  wdt_counter #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (srst_n),
    .step_i   (step),
    .reload_i (reload),
    .load_i   (load),
    .cnt_o    (cnt),
    .ovf_o    (rst_req)
  );
endmodule

// File: tb/wdt_keyed_top_tb.sv
module wdt_keyed_top_tb;
  import wdt_pkg::*;

  localparam int         DW  = 32;
  localparam logic [7:0] REV = 8'h21;

  logic          clk = 1'b0;
  logic          rst_n, tmr_tick, bus_wr;
  logic [4:0]    bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          rst_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  wdt_keyed_top #(.DATA_W(DW), .REV_ID(REV)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_tick  (tmr_tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rchk(input string req, input string what,
                      input logic [4:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] d;
    rd(a, d);
    chk(req, what, d, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic tick();
    tmr_tick = 1'b1;
    @(negedge clk);
    tmr_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic post(input logic [4:0] a, input logic [DW-1:0] d);
    wr(a, d);
    tick();
  endtask

  task automatic t_reset();
    rchk("R1", "status", A_STAT, 0);
    rchk("R1", "control", A_CTRL, 0);
    rchk("R1", "load", A_LOAD, 0);
    rchk("R1", "counter", A_CNT, 0);
    rchk("R1", "trigger", A_TRIG, 0);
    chk("R1", "rst_req", {31'd0, rst_req}, 0);
    rchk("R12", "revision", A_REV, 32'h0000_0021);
  endtask

  task automatic t_pending();
    wr(A_LOAD, 32'h100);
    rchk("R2", "load pending bit2", A_STAT, 32'h04);
    rchk("R2", "load before tick", A_LOAD, 0);
    tick();
    rchk("R2", "load pending cleared", A_STAT, 0);
    rchk("R2", "load applied", A_LOAD, 32'h100);
    wr(A_CTRL, 32'h0);
    rchk("R2", "ctrl pending bit0", A_STAT, 32'h01);
    tick();
    rchk("R2", "ctrl pending cleared", A_STAT, 0);
    wr(A_KEY, 32'h1);
    rchk("R2", "key pending bit4", A_STAT, 32'h10);
    tick();
    rchk("R2", "key pending cleared", A_STAT, 0);
  endtask

  task automatic t_collide();
    wr(A_LOAD, 32'h200);
    bus_wr = 1'b1; bus_addr = A_LOAD; bus_wdata = 32'h300; tmr_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tmr_tick = 1'b0;
    rchk("R3", "older value applied", A_LOAD, 32'h200);
    rchk("R3", "still pending", A_STAT, 32'h04);
    tick();
    rchk("R3", "newer value applied", A_LOAD, 32'h300);
    rchk("R3", "pending cleared", A_STAT, 0);
    post(A_LOAD, 32'h100);
  endtask

  task automatic t_reload_start();
    wr(A_TRIG, 32'h1234);
    rchk("R2", "trig pending bit3", A_STAT, 32'h08);
    tick();
    rchk("R7", "changed trigger reloads", A_CNT, 32'h100);
    post(A_KEY, 32'hBBBB);
    rchk("R4", "first key alone", A_CNT, 32'h100);
    post(A_KEY, 32'h4444);
    ticks(5);
    rchk("R9", "running five ticks", A_CNT, 32'h105);
  endtask

  task automatic t_trigger();
    post(A_TRIG, 32'h1234);
    rchk("R8", "repeated trigger no reload", A_CNT, 32'h106);
    post(A_TRIG, 32'hFFFF_EDCB);
    rchk("R7", "complement trigger reloads", A_CNT, 32'h100);
  endtask

  task automatic t_broken_and_stop();
    post(A_KEY, 32'hAAAA);
    post(A_KEY, 32'h1111);
    post(A_KEY, 32'h5555);
    ticks(2);
    rchk("R6", "broken stop keeps running", A_CNT, 32'h105);
    post(A_KEY, 32'hAAAA);
    post(A_KEY, 32'h5555);
    rchk("R5", "stop applied", A_CNT, 32'h107);
    ticks(4);
    rchk("R5", "stopped holds", A_CNT, 32'h107);
    post(A_KEY, 32'hBBBB);
    post(A_KEY, 32'h0000);
    post(A_KEY, 32'h4444);
    ticks(3);
    rchk("R6", "broken start stays stopped", A_CNT, 32'h107);
  endtask

  task automatic t_prescale();
    post(A_CTRL, 32'h28);
    rchk("R10", "control readback", A_CTRL, 32'h28);
    post(A_KEY, 32'hBBBB);
    post(A_KEY, 32'h4444);
    ticks(3);
    rchk("R10", "three ticks at ratio 4", A_CNT, 32'h107);
    tick();
    rchk("R10", "fourth tick steps", A_CNT, 32'h108);
    ticks(4);
    rchk("R10", "eighth tick steps", A_CNT, 32'h109);
    post(A_CTRL, 32'h0);
    ticks(2);
    rchk("R10", "prescaler off every tick", A_CNT, 32'h10B);
  endtask

  task automatic t_timeout();
    post(A_LOAD, 32'hFFFF_FFFC);
    post(A_TRIG, 32'h1234);
    rchk("R7", "reload near top", A_CNT, 32'hFFFF_FFFC);
    ticks(3);
    rchk("R11", "at all-ones", A_CNT, 32'hFFFF_FFFF);
    chk("R11", "no request before wrap", {31'd0, rst_req}, 0);
    tick();
    chk("R11", "request on wrap", {31'd0, rst_req}, 1);
    rchk("R11", "reloaded on wrap", A_CNT, 32'hFFFF_FFFC);
    @(negedge clk);
    chk("R11", "request one cycle", {31'd0, rst_req}, 0);
    post(A_KEY, 32'hAAAA);
    post(A_KEY, 32'h5555);
  endtask

  initial begin
    rst_n = 1'b0; tmr_tick = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pending();
    t_collide();
    t_reload_start();
    t_trigger();
    t_broken_and_stop();
    t_prescale();
    t_timeout();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule